// File: doc/BRIEF.md
# Parallel SCSI Controller Register Block

This block is the host-facing register file of a small parallel SCSI bus controller. A host reaches it through a 3-bit register index, an 8-bit write port and a combinational 8-bit read port. Software uses it to set the levels the controller drives onto the bus control lines and data lines. It also reads back the live bus levels, the phase comparison result and the error flags. It services a single interrupt line.

The SCSI bus appears as two sets of plain vectors. The inputs carry the logical level of each bus line, where 1 means active whichever device drives it. The outputs are open-drain style enables, where 1 means this device pulls the line active. Some register indices mean one thing on a write and another on a read. Data is driven onto the bus either during arbitration or when the assert-data bit is set and the programmed phase matches the bus. Reading index 7 acknowledges the interrupt. Arbitration timing, DMA data movement and the physical drivers are handled elsewhere.

Top module: `spc_regs`

## Requirements
- R1: Register access. A write to index 0 loads the output data byte, and a read of index 0 returns the live data lines. Index 1 is the initiator command register, index 2 the mode register and index 3 the target command register; index 3 reads back its bits 3..0 with bits 7..4 as zero. A write to index 4 loads the selection mask. Writes to indices 5, 6 and 7 change nothing, and reads of indices 6 and 7 return 0.
- R2: Control line drive. Initiator command bit 7 drives RST, bit 3 drives BSY and bit 2 drives SEL in every mode. Bit 4 drives ACK and bit 1 drives ATN only while mode bit 6 (target mode) is 0. Target command bits 3, 2, 1 and 0 drive REQ, MSG, CD and IO only while mode bit 6 is 1. Initiator command bits 6 and 5 are not stored.
- R3: The data enables equal the output data byte while mode bit 0 (arbitrate) is 1. They also equal it while initiator command bit 0 is 1 and the bus phase matches. At all other times they are zero. The parity enable is 1 exactly when data is driven and the output byte holds an even number of ones, so that the driven byte plus parity is odd.
- R4: A read of index 4 returns, from bit 7 down to bit 0, the live levels of RST, BSY, REQ, MSG, CD, IO, SEL and the data parity line.
- R5: The bus phase is {MSG, CD, IO}: data-out 000, data-in 001, command 010, status 011, message-out 110, message-in 111. The phase match bit (bus-and-status bit 3) is 1 exactly when the phase equals target command bits 2..0.
- R6: A read of index 5 returns bit 7 = 0, bit 6 = 0, bit 5 parity error, bit 4 interrupt, bit 3 phase match, bit 2 busy error, bit 1 live ATN and bit 0 live ACK.
- R7: Initiator command read bit 6 (arbitration in progress) is set after a clock edge at which mode bit 0 is 1 and both BSY and SEL are inactive. Read bit 5 (arbitration lost) is set after an edge at which arbitration is in progress, SEL is active and this device is not driving SEL. Both clear after an edge at which mode bit 0 is 0.
- R8: After a clock edge at which BSY is inactive, SEL is active and some data line that is set in the selection mask is active, the interrupt output is 1.
- R9: While mode bit 2 is 1, BSY being active at one edge and inactive at the next sets the busy error flag and the interrupt. The previous BSY level is taken as inactive after reset.
- R10: Data is checked at an edge where the handshake line becomes active. The handshake line is REQ in initiator mode and ACK in target mode; its previous level is taken as inactive after reset. If mode bit 5 is 1 and the data lines plus parity line hold an even number of ones, the parity error flag is set. The interrupt is also set only if mode bit 4 is 1 as well.
- R11: A read of index 7 that is present at a clock edge clears the parity error, busy error and interrupt flags. A set condition at the same edge takes precedence.
- R12: A synchronous active-high reset clears all writable registers and all flags. After it every bus enable is 0 and the interrupt is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hostAddr | input | 3 | Register index |
| hostWrData | input | 8 | Write data |
| hostWr | input | 1 | Write strobe, sampled at the clock edge |
| hostRd | input | 1 | Read strobe, qualifies the clear on index 7 |
| hostRdData | output | 8 | Combinational read data for hostAddr |
| irq | output | 1 | Interrupt flag |
| busDataIn | input | 8 | Live data line levels |
| busParIn | input | 1 | Live data parity line level |
| busRstIn | input | 1 | Live RST level |
| busBsyIn | input | 1 | Live BSY level |
| busSelIn | input | 1 | Live SEL level |
| busAtnIn | input | 1 | Live ATN level |
| busAckIn | input | 1 | Live ACK level |
| busReqIn | input | 1 | Live REQ level |
| busMsgIn | input | 1 | Live MSG level |
| busCdIn | input | 1 | Live CD level |
| busIoIn | input | 1 | Live IO level |
| busDataOe | output | 8 | Data line pull enables |
| busParOe | output | 1 | Parity line pull enable |
| busRstOe | output | 1 | RST pull enable |
| busBsyOe | output | 1 | BSY pull enable |
| busSelOe | output | 1 | SEL pull enable |
| busAtnOe | output | 1 | ATN pull enable |
| busAckOe | output | 1 | ACK pull enable |
| busReqOe | output | 1 | REQ pull enable |
| busMsgOe | output | 1 | MSG pull enable |
| busCdOe | output | 1 | CD pull enable |
| busIoOe | output | 1 | IO pull enable |

## Verification
The embedded properties check on every cycle that each interrupt source raises the flag one edge later. They also check that a clear with no competing source drops it, that arbitration lost never appears without arbitration in progress, that arbitration drives the output byte, and that the bus is released after reset. Only the bench scenarios show the full register map and the six phase encodings. The same holds for the parity check under good and bad data on both mode settings, the priority of a new event over a clear in the same cycle, and the writes to read-only indices having no effect.

// File: rtl/spc_pkg.sv
package spc_pkg;
  parameter int SPC_DW = 8;
  parameter int SPC_AW = 3;

  localparam logic [SPC_AW-1:0] IDX_DATA = 3'd0;
  localparam logic [SPC_AW-1:0] IDX_ICMD = 3'd1;
  localparam logic [SPC_AW-1:0] IDX_MODE = 3'd2;
  localparam logic [SPC_AW-1:0] IDX_TCMD = 3'd3;
  localparam logic [SPC_AW-1:0] IDX_STAT = 3'd4;
  localparam logic [SPC_AW-1:0] IDX_BSTS = 3'd5;
  localparam logic [SPC_AW-1:0] IDX_ACKN = 3'd7;

  localparam logic [SPC_DW-1:0] ICMD_KEEP = 8'h9F;

  typedef struct packed {
    logic wrOut;
    logic wrIcmd;
    logic wrMode;
    logic wrTcmd;
    logic wrSelMask;
    logic clrFlags;
  } strobe_t;

  typedef struct packed {
    logic arbBusy;
    logic arbLost;
    logic parErr;
    logic busyErr;
    logic irq;
  } flags_t;

  typedef struct packed {
    logic              arbitrate;
    logic              monBusy;
    logic              parCheck;
    logic              parIrq;
    logic              target;
    logic              selDrive;
    logic [SPC_DW-1:0] selMask;
  } cfg_t;

  typedef struct packed {
    logic [SPC_DW-1:0] data;
    logic par;
    logic rst;
    logic bsy;
    logic sel;
    logic atn;
    logic ack;
    logic req;
    logic msg;
    logic cd;
    logic io;
  } busIn_t;

  typedef struct packed {
    logic [SPC_DW-1:0] dataOe;
    logic parOe;
    logic rstOe;
    logic bsyOe;
    logic selOe;
    logic atnOe;
    logic ackOe;
    logic reqOe;
    logic msgOe;
    logic cdOe;
    logic ioOe;
  } busOut_t;
endpackage

// File: rtl/spc_ctrl.sv
module spc_ctrl
  import spc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [SPC_AW-1:0] hostAddr,
  input  logic              hostWr,
  input  logic              hostRd,
  input  cfg_t              cfg,
  input  logic [SPC_DW-1:0] busDataIn,
  input  logic              busParIn,
  input  logic              busBsyIn,
  input  logic              busSelIn,
  input  logic              busReqIn,
  input  logic              busAckIn,
  output strobe_t           strobes,
  output flags_t            flags
);
  logic bsyPrev, hsPrev, hsNow;
  logic selHit, busyEvt, parBad, irqSet;

  always_comb begin
    strobes = '0;
    if (hostWr) begin
      case (hostAddr)
        IDX_DATA: strobes.wrOut     = 1'b1;
        IDX_ICMD: strobes.wrIcmd    = 1'b1;
        IDX_MODE: strobes.wrMode    = 1'b1;
        IDX_TCMD: strobes.wrTcmd    = 1'b1;
        IDX_STAT: strobes.wrSelMask = 1'b1;
        default:  ;
      endcase
    end
    strobes.clrFlags = hostRd && (hostAddr == IDX_ACKN);
  end

  assign hsNow   = cfg.target ? busAckIn : busReqIn;
  assign selHit  = !busBsyIn && busSelIn && |(busDataIn & cfg.selMask);
  assign busyEvt = cfg.monBusy && bsyPrev && !busBsyIn;
  assign parBad  = hsNow && !hsPrev && cfg.parCheck && !(^{busDataIn, busParIn});
  assign irqSet  = selHit || busyEvt || (parBad && cfg.parIrq);

  always_ff @(posedge clk) begin
    if (rst) begin
      bsyPrev <= 1'b0;
      hsPrev  <= 1'b0;
      flags   <= '0;
    end else begin
      bsyPrev       <= busBsyIn;
      hsPrev        <= hsNow;
      flags.parErr  <= parBad  || (flags.parErr  && !strobes.clrFlags);
      flags.busyErr <= busyEvt || (flags.busyErr && !strobes.clrFlags);
      flags.irq     <= irqSet  || (flags.irq     && !strobes.clrFlags);
      if (!cfg.arbitrate) begin
        flags.arbBusy <= 1'b0;
        flags.arbLost <= 1'b0;
      end else begin
        if (!busBsyIn && !busSelIn) flags.arbBusy <= 1'b1;
        if (flags.arbBusy && busSelIn && !cfg.selDrive) flags.arbLost <= 1'b1;
      end
    end
  end

  assert_sel_irq_R8: assert property (@(posedge clk) disable iff (rst)
    (!busBsyIn && busSelIn && ((busDataIn & cfg.selMask) != '0)) |=> flags.irq);

  assert_busy_err_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && cfg.monBusy && $past(busBsyIn) && !busBsyIn) |=> (flags.busyErr && flags.irq));

  assert_par_gate_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(flags.parErr) |-> $past(cfg.parCheck));

  assert_clear_R11: assert property (@(posedge clk) disable iff (rst)
    (hostRd && hostAddr == IDX_ACKN && (busBsyIn || !busSelIn) && !cfg.monBusy && !cfg.parCheck)
      |=> (!flags.irq && !flags.busyErr && !flags.parErr));

  assert_lost_needs_arb_R7: assert property (@(posedge clk) disable iff (rst)
    flags.arbLost |-> flags.arbBusy);
endmodule

// File: rtl/spc_datapath.sv
module spc_datapath
  import spc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strobes,
  input  flags_t            flags,
  input  logic [SPC_AW-1:0] hostAddr,
  input  logic [SPC_DW-1:0] hostWrData,
  input  busIn_t            busIn,
  output logic [SPC_DW-1:0] hostRdData,
  output cfg_t              cfg,
  output busOut_t           busOut
);
  logic [SPC_DW-1:0] outReg, icmdReg, modeReg, selMaskReg;
  logic [3:0]        tcmdReg;
  logic [2:0]        busPhase;
  logic              phaseMatch, driveData, tgtMode;

  always_ff @(posedge clk) begin
    if (rst) begin
      outReg     <= '0;
      icmdReg    <= '0;
      modeReg    <= '0;
      tcmdReg    <= '0;
      selMaskReg <= '0;
    end else begin
      if (strobes.wrOut)     outReg     <= hostWrData;
      if (strobes.wrIcmd)    icmdReg    <= hostWrData & ICMD_KEEP;
      if (strobes.wrMode)    modeReg    <= hostWrData;
      if (strobes.wrTcmd)    tcmdReg    <= hostWrData[3:0];
      if (strobes.wrSelMask) selMaskReg <= hostWrData;
    end
  end

  assign busPhase   = {busIn.msg, busIn.cd, busIn.io};
  assign phaseMatch = (busPhase == tcmdReg[2:0]);
  assign driveData  = modeReg[0] || (icmdReg[0] && phaseMatch);
  assign tgtMode    = modeReg[6];

  always_comb begin
    busOut.dataOe = driveData ? outReg : '0;
    busOut.parOe  = driveData && !(^outReg);
    busOut.rstOe  = icmdReg[7];
    busOut.bsyOe  = icmdReg[3];
    busOut.selOe  = icmdReg[2];
    busOut.ackOe  = icmdReg[4] && !tgtMode;
    busOut.atnOe  = icmdReg[1] && !tgtMode;
    busOut.reqOe  = tcmdReg[3] && tgtMode;
    busOut.msgOe  = tcmdReg[2] && tgtMode;
    busOut.cdOe   = tcmdReg[1] && tgtMode;
    busOut.ioOe   = tcmdReg[0] && tgtMode;
  end

  always_comb begin
    cfg.arbitrate = modeReg[0];
    cfg.monBusy   = modeReg[2];
    cfg.parIrq    = modeReg[4];
    cfg.parCheck  = modeReg[5];
    cfg.target    = tgtMode;
    cfg.selDrive  = icmdReg[2];
    cfg.selMask   = selMaskReg;
  end

  always_comb begin
    case (hostAddr)
      IDX_DATA: hostRdData = busIn.data;
      IDX_ICMD: hostRdData = {icmdReg[7], flags.arbBusy, flags.arbLost, icmdReg[4:0]};
      IDX_MODE: hostRdData = modeReg;
      IDX_TCMD: hostRdData = {4'b0, tcmdReg};
      IDX_STAT: hostRdData = {busIn.rst, busIn.bsy, busIn.req, busIn.msg,
                              busIn.cd, busIn.io, busIn.sel, busIn.par};
      IDX_BSTS: hostRdData = {2'b00, flags.parErr, flags.irq, phaseMatch,
                              flags.busyErr, busIn.atn, busIn.ack};
      default:  hostRdData = '0;
    endcase
  end

  assert_arb_drive_R3: assert property (@(posedge clk) disable iff (rst)
    modeReg[0] |-> (busOut.dataOe == outReg));

  assert_rst_line_R2: assert property (@(posedge clk) disable iff (rst)
    strobes.wrIcmd |=> (busOut.rstOe == $past(hostWrData[7])));

  assert_phase_bit_R5: assert property (@(posedge clk) disable iff (rst)
    (hostAddr == IDX_BSTS && busPhase == tcmdReg[2:0]) |-> hostRdData[3]);

  assert_released_R12: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (busOut == '0 && !flags.irq));
endmodule

// File: rtl/spc_regs.sv
module spc_regs
  import spc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [SPC_AW-1:0] hostAddr,
  input  logic [SPC_DW-1:0] hostWrData,
  input  logic              hostWr,
  input  logic              hostRd,
  output logic [SPC_DW-1:0] hostRdData,
  output logic              irq,
  input  logic [SPC_DW-1:0] busDataIn,
  input  logic              busParIn,
  input  logic              busRstIn,
  input  logic              busBsyIn,
  input  logic              busSelIn,
  input  logic              busAtnIn,
  input  logic              busAckIn,
  input  logic              busReqIn,
  input  logic              busMsgIn,
  input  logic              busCdIn,
  input  logic              busIoIn,
  output logic [SPC_DW-1:0] busDataOe,
  output logic              busParOe,
  output logic              busRstOe,
  output logic              busBsyOe,
  output logic              busSelOe,
  output logic              busAtnOe,
  output logic              busAckOe,
  output logic              busReqOe,
  output logic              busMsgOe,
  output logic              busCdOe,
  output logic              busIoOe
);
  strobe_t strobes;
  flags_t  flags;
  cfg_t    cfg;
  busIn_t  busIn;
  busOut_t busOut;

  assign busIn = '{data: busDataIn, par: busParIn, rst: busRstIn, bsy: busBsyIn,
                   sel: busSelIn, atn: busAtnIn, ack: busAckIn, req: busReqIn,
                   msg: busMsgIn, cd: busCdIn, io: busIoIn};

  spc_ctrl uCtrl (
    .clk(clk), .rst(rst), .hostAddr(hostAddr), .hostWr(hostWr), .hostRd(hostRd),
    .cfg(cfg), .busDataIn(busDataIn), .busParIn(busParIn), .busBsyIn(busBsyIn),
    .busSelIn(busSelIn), .busReqIn(busReqIn), .busAckIn(busAckIn),
    .strobes(strobes), .flags(flags)
  );

  spc_datapath uPath (
    .clk(clk), .rst(rst), .strobes(strobes), .flags(flags), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .busIn(busIn), .hostRdData(hostRdData),
    .cfg(cfg), .busOut(busOut)
  );

  assign irq       = flags.irq;
  assign busDataOe = busOut.dataOe;
  assign busParOe  = busOut.parOe;
  assign busRstOe  = busOut.rstOe;
  assign busBsyOe  = busOut.bsyOe;
  assign busSelOe  = busOut.selOe;
  assign busAtnOe  = busOut.atnOe;
  assign busAckOe  = busOut.ackOe;
  assign busReqOe  = busOut.reqOe;
  assign busMsgOe  = busOut.msgOe;
  assign busCdOe   = busOut.cdOe;
  assign busIoOe   = busOut.ioOe;
endmodule

// File: tb/sim_spc_regs.sv
module sim_spc_regs;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] hostAddr = '0;
  logic [7:0] hostWrData = '0;
  logic hostWr = 1'b0, hostRd = 1'b0;
  logic [7:0] hostRdData;
  logic irq;
  logic [7:0] busDataIn = '0;
  logic busParIn = 0, busRstIn = 0, busBsyIn = 0, busSelIn = 0, busAtnIn = 0;
  logic busAckIn = 0, busReqIn = 0, busMsgIn = 0, busCdIn = 0, busIoIn = 0;
  logic [7:0] busDataOe;
  logic busParOe, busRstOe, busBsyOe, busSelOe, busAtnOe, busAckOe;
  logic busReqOe, busMsgOe, busCdOe, busIoOe;

  int nChecks = 0;
  int nFails = 0;
  bit started = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  spc_regs u0 (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wrapUp();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  // Behavioural reference state
  logic [7:0] mOut, mIcr, mMode, mMask;
  logic [3:0] mTcr;
  bit mArb, mLost, mPar, mBusy, mIrq, mBsyP, mHsP;

  always @(posedge clk) begin : model
    bit hs, selE, busE, parBad, clr, nArb, nLost;
    if (rst) begin
      mOut = 0; mIcr = 0; mMode = 0; mMask = 0; mTcr = 0;
      {mArb, mLost, mPar, mBusy, mIrq, mBsyP, mHsP} = '0;
      started = 1;
    end else begin
      hs     = mMode[6] ? busAckIn : busReqIn;
      selE   = !busBsyIn && busSelIn && ((busDataIn & mMask) != 0);
      busE   = mMode[2] && mBsyP && !busBsyIn;
      parBad = hs && !mHsP && mMode[5] && ($countones({busDataIn, busParIn}) % 2 == 0);
      clr    = hostRd && hostAddr == 3'd7;
      nArb = mArb; nLost = mLost;
      if (!mMode[0]) begin nArb = 0; nLost = 0; end
      else begin
        if (mArb && busSelIn && !mIcr[2]) nLost = 1;
        if (!busBsyIn && !busSelIn) nArb = 1;
      end
      mArb = nArb; mLost = nLost;
      mIrq  = selE || busE || (parBad && mMode[4]) || (mIrq && !clr);
      mPar  = parBad || (mPar && !clr);
      mBusy = busE || (mBusy && !clr);
      mBsyP = busBsyIn; mHsP = hs;
      if (hostWr) begin
        if (hostAddr == 0) mOut = hostWrData;
        if (hostAddr == 1) mIcr = hostWrData & 8'h9F;
        if (hostAddr == 2) mMode = hostWrData;
        if (hostAddr == 3) mTcr = hostWrData[3:0];
        if (hostAddr == 4) mMask = hostWrData;
      end
    end
  end

  // Cycle-by-cycle comparison
  always @(negedge clk) begin : compare
    bit pm, drv, tg;
    logic [7:0] expRd;
    logic [9:0] expCtl, actCtl;
    #2;
    if (started && !rst) begin
      pm  = ({busMsgIn, busCdIn, busIoIn} == mTcr[2:0]);
      drv = mMode[0] || (mIcr[0] && pm);
      tg  = mMode[6];
      case (hostAddr)
        0: expRd = busDataIn;
        1: expRd = {mIcr[7], mArb, mLost, mIcr[4:0]};
        2: expRd = mMode;
        3: expRd = {4'h0, mTcr};
        4: expRd = {busRstIn, busBsyIn, busReqIn, busMsgIn, busCdIn, busIoIn, busSelIn, busParIn};
        5: expRd = {2'b00, mPar, mIrq, pm, mBusy, busAtnIn, busAckIn};
        default: expRd = 8'h00;
      endcase
      chk(hostRdData === expRd, "R1 read data", hostRdData, expRd);
      chk(busDataOe === (drv ? mOut : 8'h00) && busParOe === (drv && ($countones(mOut) % 2 == 0)),
          "R3 data drive", {busParOe, busDataOe}, {drv && ($countones(mOut) % 2 == 0), drv ? mOut : 8'h00});
      expCtl = {mIcr[7], mIcr[3], mIcr[2], mIcr[1] & !tg, mIcr[4] & !tg,
                mTcr[3] & tg, mTcr[2] & tg, mTcr[1] & tg, mTcr[0] & tg, 1'b0};
      actCtl = {busRstOe, busBsyOe, busSelOe, busAtnOe, busAckOe,
                busReqOe, busMsgOe, busCdOe, busIoOe, 1'b0};
      chk(actCtl === expCtl, "R2 control lines", actCtl, expCtl);
      chk(irq === mIrq, "R8 interrupt", irq, mIrq);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); hostAddr = a; hostWrData = d; hostWr = 1;
    @(negedge clk); hostWr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); hostAddr = a; hostRd = 1;
    #2 v = hostRdData;
    @(negedge clk); hostRd = 0;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    wrapUp();
  end

  initial begin
    logic [7:0] v;
    logic [2:0] phases [6] = '{3'b000, 3'b001, 3'b010, 3'b011, 3'b110, 3'b111};
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;

    // R12 reset state
    rd(1, v); chk(v === 8'h00, "R12 icmd after reset", v, 0);
    chk(busDataOe === 0 && irq === 0 && busRstOe === 0, "R12 bus released", busDataOe, 0);

    // R1 data register
    busDataIn = 8'h3C;
    wr(0, 8'hA5);
    rd(0, v); chk(v === 8'h3C, "R1 live data read", v, 8'h3C);
    chk(busDataOe === 8'h00, "R3 no drive when idle", busDataOe, 0);

    // R2 / R3 initiator command drive
    wr(1, 8'hFF);
    rd(1, v); chk(v === 8'h9F, "R2 icmd readback", v, 8'h9F);
    chk({busRstOe, busAckOe, busBsyOe, busSelOe, busAtnOe} === 5'b11111, "R2 initiator lines",
        {busRstOe, busAckOe, busBsyOe, busSelOe, busAtnOe}, 5'b11111);
    chk(busDataOe === 8'hA5 && busParOe === 1'b1, "R3 phase-matched drive", {busParOe, busDataOe}, 9'h1A5);
    busCdIn = 1; tick(1);
    chk(busDataOe === 8'h00, "R3 mismatch releases data", busDataOe, 0);
    wr(3, 8'h0A);
    chk(busDataOe === 8'hA5, "R5 match command phase", busDataOe, 8'hA5);
    chk(busReqOe === 0 && busCdOe === 0, "R2 target lines off in initiator", {busReqOe, busCdOe}, 0);
    wr(2, 8'h40);
    chk({busAckOe, busAtnOe, busReqOe, busMsgOe, busCdOe, busIoOe} === 6'b001010, "R2 target mode lines",
        {busAckOe, busAtnOe, busReqOe, busMsgOe, busCdOe, busIoOe}, 6'b001010);
    rd(3, v); chk(v === 8'h0A, "R1 tcmd readback", v, 8'h0A);
    wr(2, 8'h00); wr(1, 8'h00); busCdIn = 0;

    // R5 all phases
    foreach (phases[i]) begin
      wr(3, {5'b0, phases[i]});
      {busMsgIn, busCdIn, busIoIn} = phases[i];
      rd(5, v); chk(v[3] === 1'b1, "R5 phase match", v, 8);
      {busMsgIn, busCdIn, busIoIn} = phases[i] ^ 3'b001;
      rd(5, v); chk(v[3] === 1'b0, "R5 phase mismatch", v, 0);
    end
    {busMsgIn, busCdIn, busIoIn} = 3'b000;

    // R4 / R6 status reads
    {busRstIn, busBsyIn, busReqIn, busMsgIn, busCdIn, busIoIn, busSelIn, busParIn} = 8'hF5;
    busAtnIn = 1;
    rd(4, v); chk(v === 8'hF5, "R4 bus status", v, 8'hF5);
    rd(5, v); chk((v & 8'hC3) === 8'h02, "R6 bus-and-status fields", v & 8'hC3, 8'h02);
    {busRstIn, busBsyIn, busReqIn, busMsgIn, busCdIn, busIoIn, busSelIn, busParIn} = 8'h00;
    busAtnIn = 0; tick(1);

    // R7 arbitration
    wr(2, 8'h01); tick(1);
    rd(1, v); chk(v === 8'h40, "R7 arbitration in progress", v, 8'h40);
    chk(busDataOe === 8'hA5, "R3 drive during arbitration", busDataOe, 8'hA5);
    busSelIn = 1; tick(1);
    rd(1, v); chk(v === 8'h60, "R7 arbitration lost", v, 8'h60);
    busSelIn = 0;
    wr(2, 8'h00);
    rd(1, v); chk(v === 8'h00, "R7 cleared with arbitrate off", v, 0);

    // R8 selection interrupt
    wr(4, 8'h04);
    busSelIn = 1; busDataIn = 8'h02; tick(2);
    chk(irq === 0, "R8 unmasked line ignored", irq, 0);
    busDataIn = 8'h04; tick(1); #1;
    chk(irq === 1, "R8 selection interrupt", irq, 1);
    rd(7, v); chk(v === 8'h00, "R1 index 7 reads zero", v, 0);
    chk(irq === 1, "R11 set wins over clear", irq, 1);
    busSelIn = 0; busDataIn = 8'h00; tick(1);
    rd(7, v); chk(irq === 0, "R11 clear drops interrupt", irq, 0);

    // R9 busy error
    wr(2, 8'h04);
    busBsyIn = 1; tick(2);
    busBsyIn = 0; tick(1); #1;
    chk(irq === 1, "R9 busy drop interrupt", irq, 1);
    rd(5, v); chk((v & 8'h14) === 8'h14, "R9 busy error flag", v & 8'h14, 8'h14);
    rd(7, v); rd(5, v); chk((v & 8'h34) === 8'h00, "R11 flags cleared", v & 8'h34, 0);
    wr(2, 8'h00);
    busBsyIn = 1; tick(2); busBsyIn = 0; tick(2);
    chk(irq === 0, "R9 no monitor no error", irq, 0);

    // R10 parity
    wr(2, 8'h30);
    busDataIn = 8'h03; busParIn = 0; tick(1);
    busReqIn = 1; tick(1); #1;
    chk(irq === 1, "R10 parity interrupt", irq, 1);
    rd(5, v); chk((v & 8'h30) === 8'h30, "R10 parity flag", v & 8'h30, 8'h30);
    busReqIn = 0; rd(7, v);
    wr(2, 8'h20); tick(1);
    busReqIn = 1; tick(1);
    rd(5, v); chk((v & 8'h30) === 8'h20, "R10 flag without interrupt", v & 8'h30, 8'h20);
    busReqIn = 0; rd(7, v);
    busParIn = 1; tick(1);
    busReqIn = 1; tick(1);
    rd(5, v); chk((v & 8'h20) === 8'h00, "R10 good parity accepted", v & 8'h20, 0);
    busReqIn = 0; busDataIn = 0; busParIn = 0; rd(7, v);

    // R1 ignored writes
    wr(2, 8'h00);
    wr(5, 8'hFF); wr(6, 8'hFF); wr(7, 8'hFF);
    rd(2, v); chk(v === 8'h00, "R1 writes to 5..7 ignored", v, 0);
    rd(6, v); chk(v === 8'h00, "R1 index 6 reads zero", v, 0);
    chk(busDataOe === 0 && irq === 0, "R1 no side effect", {irq, busDataOe}, 0);

    // R12 mid-run reset
    wr(1, 8'h9F); wr(2, 8'h01);
    @(negedge clk); rst = 1; tick(2); rst = 0; tick(1);
    chk(busDataOe === 0 && busRstOe === 0 && busBsyOe === 0 && irq === 0, "R12 reset releases bus",
        {busRstOe, busBsyOe, busDataOe}, 0);

    tick(3);
    wrapUp();
  end
endmodule